// File: doc/BRIEF.md
# Test Access Port Instruction Decoder

This block is the test-logic controller of a chip's boundary-scan port. It runs the sixteen-state test access port state machine on the test clock, holds a 4-bit instruction register, and routes the serial path from the test data input to the test data output through one of three data registers. These are a one-bit bypass cell, a 32-bit identification register, and an external boundary-scan chain that sits outside this block. The chain is reached through a serial pair and three strobes: capture, shift and update.

Besides the usual instructions, two extra public instructions exist. The first keeps the boundary cells driving whatever their update latches already hold, while the short bypass path is scanned. The second disables every output driver on the chip while the bypass path is scanned. Both of them hold the processor core in reset for as long as they remain the active instruction. After a reset of the test logic, the identification instruction is active, so the first bit shifted out of the data path is a 1.

Top module: `testport_ctrl`

## Requirements
- R1: The state machine enters Test-Logic-Reset when `trstN` is low (asynchronously) or after five rising edges of `tck` with `tms` high, from any state. In Test-Logic-Reset the instruction register is loaded with the identification code 0010, and `coreRstReq`, `outHiZ` and `bndHold` are low.
- R2: State changes follow the standard sixteen-state graph on each rising edge of `tck`. A data scan can be paused through Exit1-DR, Pause-DR and Exit2-DR and resumed without losing or adding bits.
- R3: In Capture-IR the instruction shift register loads 0001. Its bits are shifted out least significant bit first during Shift-IR, and the new code takes effect on the rising edge that leaves Update-IR.
- R4: Under code 0010, Capture-DR loads the identification word. Its fields are: bit 0 = 1; bits 11:1 = manufacturer code 00000001110; bits 16:12 = derivative number (parameter, default 00101); bits 21:17 = core number 00001; bits 27:22 = design-centre number 000110; bits 31:28 = version (parameter, default 0001). The word is shifted out least significant bit first.
- R5: Under the bypass code 1111, Capture-DR loads 0 into the one-bit bypass cell. Data then appears on `tdo` one shift later than it was presented on `tdi`.
- R6: `tdo` and `tdoEn` change only on falling edges of `tck`. `tdoEn` is high exactly while the state is Shift-DR or Shift-IR, and `tdo` is 0 while `tdoEn` is low.
- R7: Codes 0000 and 0001 select the external chain. `chainCapture`, `chainShift` and `chainUpdate` are high in Capture-DR, Shift-DR and Update-DR respectively, and only under these codes. `chainTdi` carries `tdi`, and `chainTdo` is routed to `tdo` during Shift-DR.
- R8: Code 0011 selects the bypass cell and drives `bndHold` = 1, `coreRstReq` = 1 and `outHiZ` = 0.
- R9: Code 0100 selects the bypass cell and drives `outHiZ` = 1, `coreRstReq` = 1 and `bndHold` = 0.
- R10: Under code 0010 or any code not named above, `coreRstReq`, `outHiZ` and `bndHold` are all 0. Codes other than 0000, 0001 and 0010 select the bypass cell.
- R11: `coreRstReq`, `outHiZ` and `bndHold` change only on leaving Update-IR or Test-Logic-Reset (or on `trstN`). They hold their values while a new instruction is being shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test-logic reset, active low |
| tms | input | 1 | Mode select sampled on rising `tck` |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling `tck` |
| tdoEn | output | 1 | Output enable for `tdo` |
| chainTdi | output | 1 | Serial data towards the boundary chain |
| chainTdo | input | 1 | Serial data returning from the boundary chain |
| chainCapture | output | 1 | Boundary chain capture strobe |
| chainShift | output | 1 | Boundary chain shift enable |
| chainUpdate | output | 1 | Boundary chain update strobe |
| coreRstReq | output | 1 | Request to hold the core in reset |
| outHiZ | output | 1 | Turn every chip output driver off |
| bndHold | output | 1 | Keep boundary update latches frozen |

## Verification
A behavioural model of the port runs beside the design and is compared on every test clock. The stimulus exercises several patterns. An identification scan straight after reset shows that the default instruction and the captured word are right. An alternating bypass scan separates a one-cycle delay from a pass-through or a stuck cell. An undefined code shows that the bypass fallback and the quiet controls apply. A boundary scan against a chain stub that captures 0xA5 shows that the strobes reach only the external path. The two extra instructions are then loaded back to back, with the controls read in the middle of the second instruction shift to show that they hold until Update-IR. A data scan paused halfway, five TMS-high cycles, and an asynchronous reset in the middle of a scan cover the state graph and both return paths to Test-Logic-Reset.

// File: rtl/testport_pkg.sv
package testport_pkg;

  localparam int IR_W = 4;
  localparam int ID_W = 32;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tapState_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0001;
  localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0010;
  localparam logic [IR_W-1:0] OP_CLAMP   = 4'b0011;
  localparam logic [IR_W-1:0] OP_HIZ     = 4'b0100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_CHAIN} drSel_e;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic   capDr;
    logic   shDr;
    logic   updDr;
    logic   shIr;
    drSel_e drSel;
    logic   irLsb;
  } ctlStrobe_t;

  function automatic tapState_e tapNext(tapState_e s, logic tms);
    tapState_e n;
    case (s)
      ST_TLR:    n = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    n = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  n = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: n = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: n = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  n = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: n = tms ? ST_SEL_DR : ST_RTI;
      default:   n = ST_TLR;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/testport_fsm.sv
module testport_fsm
  import testport_pkg::*;
(
  input  logic       tck,
  input  logic       trstN,
  input  logic       tms,
  input  logic       tdi,
  output tapState_e  tapState,
  output ctlStrobe_t strb,
  output logic       coreRstReq,
  output logic       outHiZ,
  output logic       bndHold
);

  tapState_e        stateQ;
  logic [IR_W-1:0]  irShift;
  logic [IR_W-1:0]  irActive;
  drSel_e           selNow;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) stateQ <= ST_TLR;
    else        stateQ <= tapNext(stateQ, tms);
  end

  // instruction shift stage
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= IR_CAPTURE;
    end else if (stateQ == ST_CAP_IR) begin
      irShift <= IR_CAPTURE;
    end else if (stateQ == ST_SH_IR) begin
      irShift <= {tdi, irShift[IR_W-1:1]};
    end
  end

  // active instruction: loaded on leaving Update-IR, forced in Test-Logic-Reset
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irActive <= OP_IDCODE;
    end else if (stateQ == ST_TLR) begin
      irActive <= OP_IDCODE;
    end else if (stateQ == ST_UPD_IR) begin
      irActive <= irShift;
    end
  end

  always_comb begin
    case (irActive)
      OP_EXTEST, OP_SAMPLE: selNow = SEL_CHAIN;
      OP_IDCODE:            selNow = SEL_ID;
      default:              selNow = SEL_BYP;
    endcase
  end

  assign bndHold    = (irActive == OP_CLAMP);
  assign outHiZ     = (irActive == OP_HIZ);
  assign coreRstReq = bndHold | outHiZ;

  always_comb begin
    strb.capDr = (stateQ == ST_CAP_DR);
    strb.shDr  = (stateQ == ST_SH_DR);
    strb.updDr = (stateQ == ST_UPD_DR);
    strb.shIr  = (stateQ == ST_SH_IR);
    strb.drSel = selNow;
    strb.irLsb = irShift[0];
  end

  assign tapState = stateQ;

endmodule

// File: rtl/testport_dp.sv
module testport_dp
  import testport_pkg::*;
#(
  parameter logic [ID_W-1:0] ID_VALUE = '1
)(
  input  logic       tck,
  input  logic       trstN,
  input  logic       tdi,
  input  ctlStrobe_t strb,
  input  logic       chainTdo,
  output logic       tdo,
  output logic       tdoEn
);

  logic            bypassBit;
  logic [ID_W-1:0] idShift;
  logic            serialOut;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      bypassBit <= 1'b0;
    end else if (strb.drSel == SEL_BYP) begin
      if (strb.capDr)     bypassBit <= 1'b0;
      else if (strb.shDr) bypassBit <= tdi;
    end
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      idShift <= ID_VALUE;
    end else if (strb.drSel == SEL_ID) begin
      if (strb.capDr)     idShift <= ID_VALUE;
      else if (strb.shDr) idShift <= {tdi, idShift[ID_W-1:1]};
    end
  end

  always_comb begin
    serialOut = 1'b0;
    if (strb.shIr) begin
      serialOut = strb.irLsb;
    end else if (strb.shDr) begin
      case (strb.drSel)
        SEL_ID:    serialOut = idShift[0];
        SEL_CHAIN: serialOut = chainTdo;
        default:   serialOut = bypassBit;
      endcase
    end
  end

  // output stage retimed to the falling edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= serialOut;
      tdoEn <= strb.shIr | strb.shDr;
    end
  end

endmodule

// File: rtl/testport_ctrl.sv
module testport_ctrl
  import testport_pkg::*;
#(
  parameter logic [3:0]  ID_VERSION = 4'b0001,
  parameter logic [5:0]  ID_DESIGN  = 6'b000110,
  parameter logic [4:0]  ID_CORE    = 5'b00001,
  parameter logic [4:0]  ID_DERIV   = 5'b00101,
  parameter logic [10:0] ID_MFR     = 11'b00000001110
)(
  input  logic tck,
  input  logic trstN,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdoEn,
  output logic chainTdi,
  input  logic chainTdo,
  output logic chainCapture,
  output logic chainShift,
  output logic chainUpdate,
  output logic coreRstReq,
  output logic outHiZ,
  output logic bndHold
);

  localparam logic [ID_W-1:0] ID_WORD =
    {ID_VERSION, ID_DESIGN, ID_CORE, ID_DERIV, ID_MFR, 1'b1};

  tapState_e  tapState;
  ctlStrobe_t strb;
  logic       chainSel;

  testport_fsm uCtl (
    .tck        (tck),
    .trstN      (trstN),
    .tms        (tms),
    .tdi        (tdi),
    .tapState   (tapState),
    .strb       (strb),
    .coreRstReq (coreRstReq),
    .outHiZ     (outHiZ),
    .bndHold    (bndHold)
  );

  testport_dp #(.ID_VALUE(ID_WORD)) uDp (
    .tck      (tck),
    .trstN    (trstN),
    .tdi      (tdi),
    .strb     (strb),
    .chainTdo (chainTdo),
    .tdo      (tdo),
    .tdoEn    (tdoEn)
  );

  assign chainSel     = (strb.drSel == SEL_CHAIN);
  assign chainTdi     = tdi;
  assign chainCapture = chainSel & strb.capDr;
  assign chainShift   = chainSel & strb.shDr;
  assign chainUpdate  = chainSel & strb.updDr;

endmodule

// File: rtl/testport_ctrl_chk.sv
module testport_ctrl_chk
  import testport_pkg::*;
(
  input logic      tck,
  input logic      trstN,
  input tapState_e tapState,
  input logic      tdoEn,
  input logic      chainCapture,
  input logic      chainShift,
  input logic      chainUpdate,
  input logic      coreRstReq,
  input logic      outHiZ,
  input logic      bndHold
);

  // R6: enable set on the previous falling edge must match the shift states
  a_r6_tdo_enable: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn == (tapState == ST_SH_DR || tapState == ST_SH_IR));

  // R1: leaving Test-Logic-Reset leaves every control quiet
  a_r1_reset_quiet: assert property (@(posedge tck) disable iff (!trstN)
    (tapState == ST_TLR) |=> (!coreRstReq && !outHiZ && !bndHold));

  // R7: chain strobes are exclusive and never under the core-reset instructions
  a_r7_chain_onehot: assert property (@(posedge tck) disable iff (!trstN)
    $onehot0({chainCapture, chainShift, chainUpdate}));
  a_r7_chain_quiet: assert property (@(posedge tck) disable iff (!trstN)
    (chainCapture || chainShift || chainUpdate) |-> (!coreRstReq && !outHiZ));

  // R8 / R9: the two extra instructions are exclusive and both hold the core
  a_r8_hold_reset: assert property (@(posedge tck) disable iff (!trstN)
    bndHold |-> (coreRstReq && !outHiZ));
  a_r9_hiz_reset: assert property (@(posedge tck) disable iff (!trstN)
    outHiZ |-> (coreRstReq && !bndHold));

  // R11: controls move only after Update-IR or Test-Logic-Reset
  a_r11_ctl_stable: assert property (@(posedge tck) disable iff (!trstN)
    (tapState != ST_UPD_IR && tapState != ST_TLR) |=>
      $stable({coreRstReq, outHiZ, bndHold}));

endmodule

bind testport_ctrl testport_ctrl_chk uChk (
  .tck          (tck),
  .trstN        (trstN),
  .tapState     (tapState),
  .tdoEn        (tdoEn),
  .chainCapture (chainCapture),
  .chainShift   (chainShift),
  .chainUpdate  (chainUpdate),
  .coreRstReq   (coreRstReq),
  .outHiZ       (outHiZ),
  .bndHold      (bndHold)
);

// File: tb/testport_ctrl_test.sv
`timescale 1ns/1ps
module testport_ctrl_test;

  // bench-side state numbering
  localparam int S_TLR = 0,  S_RTI = 1,  S_SDS = 2,  S_CDR = 3,  S_SDR = 4,
                 S_E1D = 5,  S_PDR = 6,  S_E2D = 7,  S_UDR = 8,  S_SIS = 9,
                 S_CIR = 10, S_SIR = 11, S_E1I = 12, S_PIR = 13, S_E2I = 14,
                 S_UIR = 15;
  localparam logic [31:0] EXP_ID =
    {4'b0001, 6'b000110, 5'b00001, 5'b00101, 11'b00000001110, 1'b1};
  localparam logic [7:0] STUB_CAP = 8'hA5;

  logic tck = 1'b0, trstN = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdoEn, chainTdi, chainTdo;
  logic chainCapture, chainShift, chainUpdate, coreRstReq, outHiZ, bndHold;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model
  int         ms = S_TLR;
  logic [3:0] mIr = 4'b0010, mIrSh = 4'b0001;
  logic       mByp = 1'b0;
  logic [31:0] mId = EXP_ID;
  logic [7:0] mChain = 8'h00;

  assign chainTdo = mChain[0];

  testport_ctrl uut (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .tdo(tdo), .tdoEn(tdoEn),
    .chainTdi(chainTdi), .chainTdo(chainTdo), .chainCapture(chainCapture),
    .chainShift(chainShift), .chainUpdate(chainUpdate),
    .coreRstReq(coreRstReq), .outHiZ(outHiZ), .bndHold(bndHold)
  );

  always #10 tck = ~tck;

  function automatic int nxt(int s, logic m);
    if (s == S_TLR) return m ? S_TLR : S_RTI;
    if (s == S_RTI || s == S_UDR || s == S_UIR) return m ? S_SDS : S_RTI;
    if (s == S_SDS) return m ? S_SIS : S_CDR;
    if (s == S_SIS) return m ? S_TLR : S_CIR;
    if (s == S_CDR || s == S_SDR) return m ? S_E1D : S_SDR;
    if (s == S_E1D || s == S_E2D) return m ? S_UDR : (s == S_E1D ? S_PDR : S_SDR);
    if (s == S_PDR) return m ? S_E2D : S_PDR;
    if (s == S_CIR || s == S_SIR) return m ? S_E1I : S_SIR;
    if (s == S_E1I || s == S_E2I) return m ? S_UIR : (s == S_E1I ? S_PIR : S_SIR);
    return m ? S_E2I : S_PIR;  // S_PIR
  endfunction

  // 0 bypass, 1 identification, 2 external chain
  function automatic int selOf(logic [3:0] c);
    if (c == 4'b0000 || c == 4'b0001) return 2;
    if (c == 4'b0010) return 1;
    return 0;
  endfunction

  task automatic check(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    int  sel;
    logic eTdo;
    sel  = selOf(mIr);
    eTdo = 1'b0;
    if (ms == S_SIR) eTdo = mIrSh[0];
    else if (ms == S_SDR) eTdo = (sel == 1) ? mId[0] : (sel == 2) ? mChain[0] : mByp;
    check("R6 tdoEn", tdoEn, (ms == S_SDR || ms == S_SIR));
    check("R6 tdo", tdo, eTdo);
    check("R7 chainCapture", chainCapture, (ms == S_CDR && sel == 2));
    check("R7 chainShift", chainShift, (ms == S_SDR && sel == 2));
    check("R7 chainUpdate", chainUpdate, (ms == S_UDR && sel == 2));
    check("R7 chainTdi", chainTdi, tdi);
    check("R8 coreRstReq", coreRstReq, (mIr == 4'b0011 || mIr == 4'b0100));
    check("R8 bndHold", bndHold, (mIr == 4'b0011));
    check("R9 outHiZ", outHiZ, (mIr == 4'b0100));
  endtask

  task automatic step(logic tmsV, logic tdiV);
    int sel;
    tms = tmsV;
    tdi = tdiV;
    @(posedge tck);
    sel = selOf(mIr);
    case (ms)
      S_TLR: mIr = 4'b0010;
      S_CIR: mIrSh = 4'b0001;
      S_SIR: mIrSh = {tdiV, mIrSh[3:1]};
      S_UIR: mIr = mIrSh;
      S_CDR: if (sel == 1) mId = EXP_ID; else if (sel == 2) mChain = STUB_CAP; else mByp = 1'b0;
      S_SDR: if (sel == 1) mId = {tdiV, mId[31:1]};
             else if (sel == 2) mChain = {tdiV, mChain[7:1]};
             else mByp = tdiV;
      default: ;
    endcase
    ms = nxt(ms, tmsV);
    @(negedge tck);
    #1;
    compareAll();
  endtask

  logic midRst, midHold;

  // from Run-Test/Idle back to Run-Test/Idle
  task automatic loadIr(logic [3:0] code);
    logic [3:0] cap;
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) begin
      cap[i] = tdo;
      if (i == 2) begin midRst = coreRstReq; midHold = bndHold; end
      step(i == 3, code[i]);
    end
    check("R3 IR capture pattern bit0", cap[0], 1'b1);
    check("R3 IR capture pattern upper", |cap[3:1], 1'b0);
    step(1, 0); step(0, 0);
  endtask

  task automatic scanDr(logic [63:0] din, int n, int pauseAt, output logic [63:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      if (pauseAt > 0 && i == pauseAt - 1 && i != n - 1) begin
        step(1, din[i]); step(0, 0); step(0, 0);
        check("R2 no drive in Pause-DR", tdoEn, 1'b0);
        step(1, 0); step(0, 0);
      end else begin
        step(i == n - 1, din[i]);
      end
    end
    step(1, 0); step(0, 0);
  endtask

  initial begin
    logic [63:0] got;
    logic [7:0]  pat;
    #35;
    check("R1 reset tdoEn", tdoEn, 1'b0);
    check("R1 reset coreRstReq", coreRstReq, 1'b0);
    check("R1 reset outHiZ", outHiZ, 1'b0);
    check("R1 reset bndHold", bndHold, 1'b0);
    @(negedge tck); #5; trstN = 1'b1;
    @(negedge tck); #1;
    step(0, 0);

    // identification word straight after reset
    scanDr(64'h0, 32, 0, got);
    for (int i = 0; i < 32; i++) check("R4 id bit", got[i], EXP_ID[i]);
    check("R1 first bit after reset is one", got[0], 1'b1);

    // bypass with alternating data
    pat = 8'b1011_0010;
    loadIr(4'b1111);
    scanDr({56'h0, pat}, 8, 0, got);
    for (int i = 0; i < 8; i++)
      check("R5 bypass delay", got[i], (i == 0) ? 1'b0 : pat[i-1]);

    // undefined code falls back to bypass, with a pause in the middle
    loadIr(4'b0111);
    check("R10 undefined quiet", coreRstReq | outHiZ | bndHold, 1'b0);
    scanDr({56'h0, ~pat}, 8, 4, got);
    for (int i = 0; i < 8; i++)
      check("R2 paused bypass", got[i], (i == 0) ? 1'b0 : ~pat[i-1]);

    // external chain
    loadIr(4'b0000);
    scanDr({56'h0, 8'h3C}, 8, 0, got);
    for (int i = 0; i < 8; i++) check("R7 chain data", got[i], STUB_CAP[i]);
    check("R7 chain shifted in", mChain == 8'h3C, 1'b1);

    // hold instruction, then tri-state instruction
    loadIr(4'b0011);
    check("R8 hold active", bndHold & coreRstReq & ~outHiZ, 1'b1);
    scanDr({56'h0, pat}, 8, 0, got);
    check("R8 bypass path", got[0], 1'b0);
    check("R8 bypass delay", got[1], pat[0]);
    loadIr(4'b0100);
    check("R11 hold kept during IR shift", midRst & midHold, 1'b1);
    check("R9 hiz active", outHiZ & coreRstReq & ~bndHold, 1'b1);
    scanDr({56'h0, pat}, 8, 0, got);
    check("R9 bypass delay", got[3], pat[2]);

    // five TMS-high cycles
    for (int i = 0; i < 5; i++) step(1, 0);
    check("R1 tms reset clears hiz", outHiZ | coreRstReq, 1'b0);
    step(0, 0);
    loadIr(4'b0010);
    check("R10 idcode quiet", coreRstReq | outHiZ | bndHold, 1'b0);

    // asynchronous reset in the middle of a data scan
    loadIr(4'b0011);
    step(1, 0); step(0, 0); step(0, 0); step(0, 1);
    trstN = 1'b0;
    #1;
    check("R1 async reset tdoEn", tdoEn, 1'b0);
    check("R1 async reset coreRstReq", coreRstReq, 1'b0);
    ms = S_TLR; mIr = 4'b0010;
    @(negedge tck); #5; trstN = 1'b1;
    @(negedge tck); #1;
    step(0, 0);
    scanDr(64'h0, 32, 0, got);
    check("R1 idcode after async reset", got[31:0] == EXP_ID, 1'b1);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule